// File: doc/BRIEF.md
# DMA Auto-Alignment Access Sizer

This block sits inside a DMA channel and decides how wide each bus access of a block transfer is. The channel loads the two start addresses, their two programmed size codes, the byte count, an auto-align enable and the two address-increment bits. It then pulses `step` once for each access it performs. For the current access the block presents the width in bytes. It also reports which address register is being aligned, holds the running addresses and the remaining count, and raises a configuration-error flag. The data packing buffer and the bus protocol belong to other blocks.

With auto-alignment on, one side is chosen as the aligned side. The source is chosen when its programmed width is at least the destination's; otherwise the destination is chosen. On the aligned side, the access width grows as the address reaches wider boundaries, up to the programmed width. Near the end of the block, the remaining count decides the width instead. The aligned address always advances. The other side advances only if its increment bit is set, and it is the side that is checked for a bad configuration. With auto-alignment off, the source's programmed width sets the access width, trimmed to the bytes that remain.

Top module: `dmaAlignSeq`

## Requirements
- R1: A `load` pulse captures the configuration on that clock edge. `active` is 1 afterwards when the loaded count is non-zero, and stays 0 when it is zero. A load while active restarts the sequence.
- R2: Size codes are 2'b00 = 4 bytes, 2'b10 = 2 bytes, 2'b01 = 1 byte and 2'b11 = reserved. A reserved code counts as 1 byte in every width decision.
- R3: With auto-align set, `alignSrc`=1 and `alignDst`=0 when the source width is greater than or equal to the destination width; otherwise `alignDst`=1 and `alignSrc`=0. Both are 0 when auto-align is clear or the block is idle.
- R4: With auto-align set and remaining count >= 16, `accBytes` is the widest of 4/2/1 that divides the aligned-side address, capped at that side's programmed width.
- R5: With auto-align set and remaining count < 16, `accBytes` is the widest of 4/2/1 that does not exceed the remaining count, capped at the aligned side's programmed width. The address plays no part.
- R6: With auto-align clear, `accBytes` is the widest of 4/2/1 that does not exceed both the remaining count and the source's programmed width.
- R7: On each accepted step, the aligned-side address increases by `accBytes`, whatever its increment bit is.
- R8: On each accepted step, an address that is not aligned increases by `accBytes` only when its increment bit is 1.
- R9: Each accepted step lowers `remCount` by `accBytes`. `active` clears on the step that brings it to 0. `accBytes` is 0 while idle.
- R10: A step while idle changes no address and no count.
- R11: `cfgErr` is 1 while active if either size code is reserved or a checked address is not a multiple of its side's width. With auto-align set, only the side that is not aligned is checked; with it clear, both sides are checked.
- R12: Source 0x0001, count 0xF0, source code 00 and destination code 01, with auto-align set, give 62 accesses. The first is 1 byte at 0x0001, then 2 bytes at 0x0002, then 4-byte accesses from 0x0004 through 0x00EC, and last 1 byte at 0x00F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture configuration and start a sequence |
| step | input | 1 | Advance one access |
| cfgSrcAddr | input | ADDR_W | Source start address |
| cfgDstAddr | input | ADDR_W | Destination start address |
| cfgSrcSize | input | 2 | Source size code |
| cfgDstSize | input | 2 | Destination size code |
| cfgCount | input | CNT_W | Byte count |
| cfgAutoAlign | input | 1 | Auto-alignment enable |
| cfgSrcInc | input | 1 | Source address increment enable |
| cfgDstInc | input | 1 | Destination address increment enable |
| active | output | 1 | Sequence in progress |
| accBytes | output | 3 | Width of current access in bytes (0 when idle) |
| alignSrc | output | 1 | Source is the aligned side |
| alignDst | output | 1 | Destination is the aligned side |
| srcAddr | output | ADDR_W | Current source address |
| dstAddr | output | ADDR_W | Current destination address |
| remCount | output | CNT_W | Bytes remaining |
| cfgErr | output | 1 | Configuration error on a checked side |

## Verification
The hardest point to reach is the handover from the address rule to the count rule. It occurs only when an odd start address and a count close to 16 leave the aligned address unaligned just as the count falls below 16. With the wrong rule there, the widths that follow differ. Random stimulus keeps counts mostly between 0 and 40 and start addresses at every low-bit offset, so this handover happens in many sequences. Steps are withheld at random to hold states and to test idle steps. A directed run of the 240-byte example checks the full width sequence, including the final byte at 0x00F0.

// File: rtl/dmaAlignPkg.sv
package dmaAlignPkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } sizeCodeT;

  typedef struct packed {
    logic loadCfg;
    logic advance;
  } ctrlStrobeT;

  // R2: code to byte width, reserved counts as a single byte
  function automatic logic [2:0] codeBytes(input logic [1:0] code);
    case (code)
      SZ_LONG: codeBytes = 3'd4;
      SZ_WORD: codeBytes = 3'd2;
      default: codeBytes = 3'd1;
    endcase
  endfunction

  function automatic logic misaligned(input logic [1:0] low, input logic [2:0] width);
    misaligned = (width == 3'd4) ? (low != 2'b00) :
                 (width == 3'd2) ? low[0] : 1'b0;
  endfunction

endpackage

// File: rtl/dmaAlignSizer.sv
module dmaAlignSizer
  import dmaAlignPkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic             autoAlign,
  input  logic [1:0]       addrLow,
  input  logic [CNT_W-1:0] remCount,
  input  logic [2:0]       capBytes,
  output logic [2:0]       accBytes
);

  localparam int SMALL_LIMIT = 16;

  logic       cntSmall;
  logic [2:0] cntFit;
  logic [2:0] addrFit;
  logic [2:0] limit;
  logic [2:0] chosen;

  always_comb begin
    cntSmall = remCount < CNT_W'(SMALL_LIMIT);
    if (remCount >= CNT_W'(4))      cntFit = 3'd4;
    else if (remCount >= CNT_W'(2)) cntFit = 3'd2;
    else                            cntFit = 3'd1;
    if (addrLow == 2'b00)           addrFit = 3'd4;
    else if (!addrLow[0])           addrFit = 3'd2;
    else                            addrFit = 3'd1;
    // R4/R5/R6 rule selection
    if (autoAlign && !cntSmall) limit = addrFit;
    else                        limit = cntFit;
    chosen   = (limit < capBytes) ? limit : capBytes;
    accBytes = active ? chosen : 3'd0;
  end

  // R9: never overrun the remaining count
  a_r9_within_count: assert property (@(posedge clk) disable iff (!rstN)
    active |-> ({{(CNT_W-3){1'b0}}, accBytes} <= remCount));

  // R4: address rule yields a naturally aligned access
  a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (active && autoAlign && remCount >= CNT_W'(SMALL_LIMIT)) |-> !misaligned(addrLow, accBytes));

endmodule

// File: rtl/dmaAlignCtrl.sv
module dmaAlignCtrl
  import dmaAlignPkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic [CNT_W-1:0] remCount,
  input  logic [2:0]       accBytes,
  input  logic             aaMode,
  input  logic [1:0]       srcCode,
  input  logic [1:0]       dstCode,
  input  logic [1:0]       srcLow,
  input  logic [1:0]       dstLow,
  output ctrlStrobeT       strobe,
  output logic             active,
  output logic             alignSrc,
  output logic             alignDst,
  output logic [2:0]       capBytes,
  output logic [1:0]       alignedLow,
  output logic             cfgErr
);

  logic [2:0] srcBytes;
  logic [2:0] dstBytes;
  logic       srcWins;
  logic       lastAccess;
  logic       reservedUsed;
  logic       srcBad;
  logic       dstBad;

  always_comb begin
    srcBytes   = codeBytes(srcCode);
    dstBytes   = codeBytes(dstCode);
    srcWins    = srcBytes >= dstBytes;          // R3 precedence, tie to source
    alignSrc   = active && aaMode && srcWins;
    alignDst   = active && aaMode && !srcWins;
    capBytes   = (!aaMode || srcWins) ? srcBytes : dstBytes;
    alignedLow = (!aaMode || srcWins) ? srcLow : dstLow;

    strobe.loadCfg = load;
    strobe.advance = step && active && !load;
    lastAccess     = remCount == {{(CNT_W-3){1'b0}}, accBytes};

    reservedUsed = (srcCode == SZ_RSVD) || (dstCode == SZ_RSVD);
    srcBad       = misaligned(srcLow, srcBytes);
    dstBad       = misaligned(dstLow, dstBytes);
    if (!active)     cfgErr = 1'b0;
    else if (aaMode) cfgErr = reservedUsed || (srcWins ? dstBad : srcBad);
    else             cfgErr = reservedUsed || srcBad || dstBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              active <= 1'b0;
    else if (strobe.loadCfg)                active <= cfgCount != '0;
    else if (strobe.advance && lastAccess)  active <= 1'b0;
  end

  a_r3_single_side: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({alignSrc, alignDst}));

  // R9: active ends exactly when the count is exhausted
  a_r9_idle_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && lastAccess) |=> !active);

  a_r1_load_starts: assert property (@(posedge clk) disable iff (!rstN)
    (load && cfgCount != '0) |=> active);

endmodule

// File: rtl/dmaAlignDatapath.sv
module dmaAlignDatapath
  import dmaAlignPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [1:0]        cfgSrcSize,
  input  logic [1:0]        cfgDstSize,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgAutoAlign,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  input  logic [2:0]        accBytes,
  input  logic              alignSrc,
  input  logic              alignDst,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  remCount,
  output logic [1:0]        srcCode,
  output logic [1:0]        dstCode,
  output logic              aaMode
);

  logic              srcIncR;
  logic              dstIncR;
  logic [ADDR_W-1:0] stepAddr;
  logic [CNT_W-1:0]  stepCnt;

  assign stepAddr = {{(ADDR_W-3){1'b0}}, accBytes};
  assign stepCnt  = {{(CNT_W-3){1'b0}}, accBytes};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      remCount <= '0;
      srcCode  <= 2'b00;
      dstCode  <= 2'b00;
      aaMode   <= 1'b0;
      srcIncR  <= 1'b0;
      dstIncR  <= 1'b0;
    end else if (strobe.loadCfg) begin
      srcAddr  <= cfgSrcAddr;
      dstAddr  <= cfgDstAddr;
      remCount <= cfgCount;
      srcCode  <= cfgSrcSize;
      dstCode  <= cfgDstSize;
      aaMode   <= cfgAutoAlign;
      srcIncR  <= cfgSrcInc;
      dstIncR  <= cfgDstInc;
    end else if (strobe.advance) begin
      remCount <= remCount - stepCnt;
      if (alignSrc || srcIncR) srcAddr <= srcAddr + stepAddr;
      if (alignDst || dstIncR) dstAddr <= dstAddr + stepAddr;
    end
  end

  a_r9_count_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.loadCfg) |=> remCount == $past(remCount) - $past(stepCnt));

  a_r7_src_forced: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && alignSrc) |=> srcAddr == $past(srcAddr) + $past(stepAddr));

  a_r7_dst_forced: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && alignDst) |=> dstAddr == $past(dstAddr) + $past(stepAddr));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.loadCfg) |=> ($stable(srcAddr) && $stable(dstAddr) && $stable(remCount)));

endmodule

// File: rtl/dmaAlignSeq.sv
module dmaAlignSeq
  import dmaAlignPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [1:0]        cfgSrcSize,
  input  logic [1:0]        cfgDstSize,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              cfgAutoAlign,
  input  logic              cfgSrcInc,
  input  logic              cfgDstInc,
  output logic              active,
  output logic [2:0]        accBytes,
  output logic              alignSrc,
  output logic              alignDst,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  remCount,
  output logic              cfgErr
);

  ctrlStrobeT strobe;
  logic [1:0] srcCode;
  logic [1:0] dstCode;
  logic       aaMode;
  logic [2:0] capBytes;
  logic [1:0] alignedLow;

  dmaAlignCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .load       (load),
    .step       (step),
    .cfgCount   (cfgCount),
    .remCount   (remCount),
    .accBytes   (accBytes),
    .aaMode     (aaMode),
    .srcCode    (srcCode),
    .dstCode    (dstCode),
    .srcLow     (srcAddr[1:0]),
    .dstLow     (dstAddr[1:0]),
    .strobe     (strobe),
    .active     (active),
    .alignSrc   (alignSrc),
    .alignDst   (alignDst),
    .capBytes   (capBytes),
    .alignedLow (alignedLow),
    .cfgErr     (cfgErr)
  );

  dmaAlignDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgSrcAddr   (cfgSrcAddr),
    .cfgDstAddr   (cfgDstAddr),
    .cfgSrcSize   (cfgSrcSize),
    .cfgDstSize   (cfgDstSize),
    .cfgCount     (cfgCount),
    .cfgAutoAlign (cfgAutoAlign),
    .cfgSrcInc    (cfgSrcInc),
    .cfgDstInc    (cfgDstInc),
    .accBytes     (accBytes),
    .alignSrc     (alignSrc),
    .alignDst     (alignDst),
    .srcAddr      (srcAddr),
    .dstAddr      (dstAddr),
    .remCount     (remCount),
    .srcCode      (srcCode),
    .dstCode      (dstCode),
    .aaMode       (aaMode)
  );

  dmaAlignSizer #(.CNT_W(CNT_W)) u_sizer (
    .clk       (clk),
    .rstN      (rstN),
    .active    (active),
    .autoAlign (aaMode),
    .addrLow   (alignedLow),
    .remCount  (remCount),
    .capBytes  (capBytes),
    .accBytes  (accBytes)
  );

endmodule

// File: tb/dmaAlignSeq_tb.sv
module dmaAlignSeq_tb;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic load = 1'b0;
  logic step = 1'b0;
  logic [ADDR_W-1:0] cfgSrcAddr = '0;
  logic [ADDR_W-1:0] cfgDstAddr = '0;
  logic [1:0] cfgSrcSize = 2'b00;
  logic [1:0] cfgDstSize = 2'b00;
  logic [CNT_W-1:0] cfgCount = '0;
  logic cfgAutoAlign = 1'b0;
  logic cfgSrcInc = 1'b0;
  logic cfgDstInc = 1'b0;
  logic active;
  logic [2:0] accBytes;
  logic alignSrc, alignDst, cfgErr;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [CNT_W-1:0] remCount;

  int errors = 0;
  int checks = 0;

  // model state
  logic [31:0] mSrc, mDst, mCnt;
  logic [1:0]  mSc, mDc;
  logic        mAa, mSi, mDi, mAct;

  always #5 clk = ~clk;

  dmaAlignSeq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .load(load), .step(step),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr),
    .cfgSrcSize(cfgSrcSize), .cfgDstSize(cfgDstSize),
    .cfgCount(cfgCount), .cfgAutoAlign(cfgAutoAlign),
    .cfgSrcInc(cfgSrcInc), .cfgDstInc(cfgDstInc),
    .active(active), .accBytes(accBytes), .alignSrc(alignSrc),
    .alignDst(alignDst), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .remCount(remCount), .cfgErr(cfgErr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // R2 widths
  function automatic int wOf(input logic [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b10) ? 2 : 1;
  endfunction

  function automatic bit srcSide();
    return wOf(mSc) >= wOf(mDc);
  endfunction

  function automatic int expBytes();
    int cap, lim, lowA;
    if (!mAct) return 0;
    cap  = (!mAa || srcSide()) ? wOf(mSc) : wOf(mDc);
    lowA = (!mAa || srcSide()) ? int'(mSrc % 4) : int'(mDst % 4);
    if (mAa && mCnt >= 16) begin
      lim = 4;
      while (lowA % lim != 0) lim = lim / 2;
    end else begin
      lim = 4;
      while (lim > int'(mCnt)) lim = lim / 2;
    end
    return (lim < cap) ? lim : cap;
  endfunction

  function automatic bit badAddr(input logic [31:0] a, input int w);
    return (a % w) != 0;
  endfunction

  function automatic bit expErr();
    bit rsv;
    if (!mAct) return 1'b0;
    rsv = (mSc == 2'b11) || (mDc == 2'b11);
    if (mAa) return rsv || (srcSide() ? badAddr(mDst, wOf(mDc)) : badAddr(mSrc, wOf(mSc)));
    return rsv || badAddr(mSrc, wOf(mSc)) || badAddr(mDst, wOf(mDc));
  endfunction

  task automatic checkAll();
    chk("R1 active", {31'd0, active}, {31'd0, mAct});
    chk("R4/R5/R6 accBytes", {29'd0, accBytes}, 32'(expBytes()));
    chk("R3 alignSrc", {31'd0, alignSrc}, {31'd0, mAct && mAa && srcSide()});
    chk("R3 alignDst", {31'd0, alignDst}, {31'd0, mAct && mAa && !srcSide()});
    chk("R7/R8 srcAddr", srcAddr, mSrc);
    chk("R7/R8 dstAddr", dstAddr, mDst);
    chk("R9 remCount", 32'(remCount), mCnt);
    chk("R11 cfgErr", {31'd0, cfgErr}, {31'd0, expErr()});
  endtask

  // drive at negedge, the edge in between applies it, check at next negedge
  task automatic doLoad(input logic [31:0] sa, input logic [31:0] da, input logic [1:0] sc,
                        input logic [1:0] dc, input logic [31:0] cnt, input bit aa,
                        input bit si, input bit di);
    cfgSrcAddr = sa; cfgDstAddr = da; cfgSrcSize = sc; cfgDstSize = dc;
    cfgCount = cnt[CNT_W-1:0]; cfgAutoAlign = aa; cfgSrcInc = si; cfgDstInc = di;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    mSrc = sa; mDst = da; mSc = sc; mDc = dc; mCnt = cnt; mAa = aa; mSi = si; mDi = di;
    mAct = cnt != 0;
    checkAll();
  endtask

  task automatic doStep(input bit en);
    int b;
    bit sSide;
    b = expBytes();
    sSide = mAa && srcSide();
    step = en;
    @(negedge clk);
    step = 1'b0;
    if (en && mAct) begin
      if (sSide || mSi) mSrc = mSrc + 32'(b);
      if ((mAa && !sSide) || mDi) mDst = mDst + 32'(b);
      mCnt = mCnt - 32'(b);
      if (mCnt == 0) mAct = 1'b0;
    end
    checkAll();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seqLen;
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    mSrc = 0; mDst = 0; mCnt = 0; mSc = 0; mDc = 0; mAa = 0; mSi = 0; mDi = 0; mAct = 0;
    repeat (3) @(negedge clk);
    // reset state
    checkAll();
    rstN = 1'b1;
    @(negedge clk);
    // R10: step while idle
    doStep(1'b1);

    // R12: 240-byte example, widths verified in order
    doLoad(32'h1, 32'h1000, 2'b00, 2'b01, 32'hF0, 1'b1, 1'b0, 1'b1);
    chk("R12 first byte", {29'd0, accBytes}, 32'd1);
    seqLen = 0;
    while (mAct) begin
      if (seqLen == 1) chk("R12 word at 2", {29'd0, accBytes}, 32'd2);
      if (seqLen == 2) chk("R12 long at 4", srcAddr, 32'h4);
      if (mSrc == 32'hF0) chk("R12 final byte at F0", {29'd0, accBytes}, 32'd1);
      seqLen++;
      doStep(1'b1);
    end
    chk("R12 access count", 32'(seqLen), 32'd62);

    // R1: zero count stays idle
    doLoad(32'h10, 32'h20, 2'b00, 2'b00, 32'd0, 1'b1, 1'b1, 1'b1);
    // R2/R11: reserved code flags error, tie goes to source (R3)
    doLoad(32'h4, 32'h8, 2'b11, 2'b01, 32'd5, 1'b1, 1'b0, 1'b0);
    chk("R11 reserved", {31'd0, cfgErr}, 32'd1);
    doStep(1'b1);
    // R11: only non-aligned side checked (dst aligned, src odd)
    doLoad(32'h3, 32'h2, 2'b01, 2'b00, 32'd20, 1'b1, 1'b1, 1'b0);
    chk("R11 unchecked aligned side", {31'd0, cfgErr}, 32'd0);
    // R1: reload while active restarts
    doStep(1'b1);
    doLoad(32'h2, 32'h6, 2'b10, 2'b10, 32'd3, 1'b0, 1'b1, 1'b1);
    doStep(1'b1); doStep(1'b1); doStep(1'b1);

    // random sequences
    for (int s = 0; s < 400; s++) begin
      logic [31:0] sa, da, cnt;
      sa  = $urandom() & 32'hFFFF;
      da  = $urandom() & 32'hFFFF;
      cnt = ($urandom() % 4 == 0) ? ($urandom() % 80) : ($urandom() % 41);
      doLoad(sa, da, 2'($urandom()), 2'($urandom()), cnt,
             1'($urandom() % 4 != 0), 1'($urandom()), 1'($urandom()));
      for (int k = 0; k < 90 && mAct; k++) doStep(1'($urandom() % 5 != 0));
      doStep(1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule